// File: doc/BRIEF.md
# Buffered Start-Stop Serial Transmitter

This block sends bytes one character at a time on a single serial output line. A host pushes bytes into a 16-entry queue through a simple write strobe. The transmitter takes them out in order and sends each one as a character frame. The bit rate comes from an external enable pulse, `baud_tick`, which fires once per bit period. Only the transmit direction is covered here, so it works independently of any receiver beside it.

The character format is set by four static inputs: 7 or 8 data bits, no parity or even/odd parity, and 1 or 2 stop bits. The format is taken when a frame begins. A clear-to-send input sets the pace: it gates the start of each new frame, and a frame already on the line always runs to the end. The `empty_req` output shows that the queue has drained, and it can serve as an interrupt or as a DMA trigger. A `clk_stop` input freezes the whole block, which stands in for gating its clock.

Top module: `sertx_fifo`

## Requirements
- R1: After reset, `txd` is 1, `empty_req` is 1 and `overflow` is 0. Whenever no frame is being sent, `txd` is 1.
- R2: A frame is one 0 start bit, then the data bits LSB first, then the parity bit if enabled, then the stop bits at 1. `txd` changes only on the clock edge that samples `baud_tick` high, so each bit lasts exactly one tick period.
- R3: `data8`=1 sends 8 data bits. `data8`=0 sends `wr_data[6:0]` and ignores bit 7.
- R4: `par_en`=0 sends no parity bit. `par_en`=1 adds one bit after the data. With `par_odd`=0 the count of ones in the data plus the parity bit is even; with `par_odd`=1 it is odd.
- R5: `stop2`=0 sends one stop bit and `stop2`=1 sends two.
- R6: The queue holds 16 bytes and sends them in write order. When another byte is waiting at the end of a frame and `cts` is 1, the next start bit follows the last stop bit with no idle bit between them.
- R7: A new frame starts only on a tick where `cts` is 1. Dropping `cts` does not cut short a frame that has already started.
- R8: A write while the queue holds 16 bytes is dropped, even if a byte leaves in the same cycle. It sets `overflow`, which stays 1 until reset.
- R9: `empty_req` is 1 whenever the queue is empty, including while the last frame is still being sent. It falls on the cycle after a write is accepted.
- R10: While `clk_stop` is 1, writes and ticks are ignored and `txd`, `empty_req` and `overflow` hold their values.
- R11: The format inputs are taken at the start bit. Changing them during a frame affects only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_stop | input | 1 | Freezes all state while 1 |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Write strobe for the queue |
| wr_data | input | 8 | Byte to queue |
| data8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| stop2 | input | 1 | 1: two stop bits, 0: one |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| cts | input | 1 | Clear to send, active high |
| txd | output | 1 | Serial output, idles high |
| empty_req | output | 1 | Queue empty request (interrupt or DMA) |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
The bench goes after each frame format, and after bit 7 being set when only seven data bits are sent. A design that skipped the mask or counted bits wrong would put extra or missing bits on the line, or a wrong parity bit.

Back-to-back frames catch a design that adds an idle bit between characters. A write into a full queue in the same cycle as a pop catches a design that accepts it, which would show up later as an extra frame.

Dropping `cts` in the middle of a frame catches a design that cuts the frame short, and also one that starts the next frame anyway. Format changes in the middle of a frame, and freeze periods with writes and ticks still arriving, catch a design that reads the format at the wrong time or lets a stopped block move.

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_stop,
  input  logic       baud_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       data8,
  input  logic       stop2,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       cts,
  output logic       txd,
  output logic       empty_req,
  output logic       overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          active;
  logic [10:0]   sh;
  logic [3:0]    rem;
  logic [10:0]   frame;

  wire       run       = !clk_stop;
  wire       full      = (count == CW'(DEPTH));
  wire       wr_ok     = run && wr_en && !full;
  wire       pop       = run && baud_tick && cts && (count != '0) && (!active || rem == 4'd0);
  wire [7:0] head      = mem[rd_ptr];
  wire [7:0] dmask     = data8 ? head : {1'b0, head[6:0]};
  wire       pbit      = (^dmask) ^ par_odd;
  wire [3:0] nbits     = 4'd8 + {3'b0, data8} + {3'b0, par_en} + {3'b0, stop2};

  always_comb begin
    case ({data8, par_en})
      2'b11:   frame = {2'b11, pbit, head};
      2'b10:   frame = {3'b111, head};
      2'b01:   frame = {3'b111, pbit, head[6:0]};
      default: frame = {4'b1111, head[6:0]};
    endcase
  end

  assign empty_req = (count == '0);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)   rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (wr_ok && !pop)      count <= count + 1'b1;
      else if (pop && !wr_ok) count <= count - 1'b1;
      if (run && wr_en && full) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      txd    <= 1'b1;
      sh     <= '1;
      rem    <= '0;
    end else if (run && baud_tick) begin
      if (pop) begin
        active <= 1'b1;
        txd    <= 1'b0;
        sh     <= frame;
        rem    <= nbits;
      end else if (active && rem != 4'd0) begin
        txd <= sh[0];
        sh  <= {1'b1, sh[10:1]};
        rem <= rem - 4'd1;
      end else begin
        active <= 1'b0;
        txd    <= 1'b1;
      end
    end
  end
endmodule

module sertx_fifo_chk #(
  parameter int DEPTH = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         clk_stop,
  input logic                         baud_tick,
  input logic                         wr_en,
  input logic                         cts,
  input logic                         txd,
  input logic                         empty_req,
  input logic                         overflow,
  input logic                         active,
  input logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int CW = $clog2(DEPTH + 1);

  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> txd);

  a_r2_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stop || !baud_tick) |=> $stable(txd));

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r7_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !cts) |=> !active);

  a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clk_stop && count == CW'(DEPTH)) |=> overflow);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r9_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_req && !(wr_en && !clk_stop)) |=> empty_req);

  a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |=> ($stable(count) && $stable(active) && $stable(txd) && $stable(overflow)));
endmodule

bind sertx_fifo sertx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_stop(clk_stop), .baud_tick(baud_tick),
  .wr_en(wr_en), .cts(cts), .txd(txd), .empty_req(empty_req),
  .overflow(overflow), .active(active), .count(count)
);

// File: tb/sertx_fifo_bench.sv
module sertx_fifo_bench;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_stop = 1'b0, baud_tick = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic data8 = 1'b1, stop2 = 1'b0, par_en = 1'b0, par_odd = 1'b0, cts = 1'b1;
  logic txd, empty_req, overflow;

  always #5 clk = ~clk;

  sertx_fifo #(.DEPTH(DEPTH)) u_sertx_fifo (
    .clk(clk), .rst_n(rst_n), .clk_stop(clk_stop), .baud_tick(baud_tick),
    .wr_en(wr_en), .wr_data(wr_data), .data8(data8), .stop2(stop2),
    .par_en(par_en), .par_odd(par_odd), .cts(cts), .txd(txd),
    .empty_req(empty_req), .overflow(overflow)
  );

  int    compared = 0, mismatched = 0, cycles = 0;
  int    div = 3, div_cnt = 0;
  string cur_req = "R1";
  int    q[$];
  bit    bits[$];
  bit    m_active = 1'b0, m_txd = 1'b1, m_ovf = 1'b0;

  task automatic chk(string req, string what, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic load_frame(int b);
    int n = data8 ? 8 : 7;
    int ones = 0;
    for (int i = 0; i < n; i++) begin
      bits.push_back(b[i]);
      ones += b[i];
    end
    if (par_en) bits.push_back(bit'(ones % 2) ^ par_odd);
    bits.push_back(1'b1);
    if (stop2) bits.push_back(1'b1);
  endtask

  task automatic cyc();
    bit full, can;
    int b;
    @(posedge clk);
    cycles++;
    if (!rst_n) begin
      q.delete(); bits.delete();
      m_active = 1'b0; m_txd = 1'b1; m_ovf = 1'b0;
    end else if (!clk_stop) begin
      full = (q.size() == DEPTH);
      if (baud_tick) begin
        can = cts && q.size() > 0 && (!m_active || bits.size() == 0);
        if (m_active && bits.size() > 0) m_txd = bits.pop_front();
        else if (can) begin
          b = q.pop_front();
          load_frame(b);
          m_active = 1'b1;
          m_txd = 1'b0;
        end else begin
          m_active = 1'b0;
          m_txd = 1'b1;
        end
      end
      if (wr_en) begin
        if (full) m_ovf = 1'b1;
        else q.push_back(int'(wr_data));
      end
    end
    @(negedge clk);
    if (rst_n) begin
      chk(cur_req, "txd", txd, m_txd);
      chk(cur_req, "empty_req", empty_req, q.size() == 0);
      chk(cur_req, "overflow", overflow, m_ovf);
    end
    if (div_cnt >= div - 1) begin baud_tick = 1'b1; div_cnt = 0; end
    else begin baud_tick = 1'b0; div_cnt++; end
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic wr(logic [7:0] b);
    wr_en = 1'b1;
    wr_data = b;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (q.size() > 0 || m_active) cyc();
    repeat (3) cyc();
  endtask

  initial begin
    repeat (4) cyc();
    rst_n = 1'b1;
    cyc();
    chk("R1", "reset txd", txd, 1'b1);
    chk("R1", "reset empty_req", empty_req, 1'b1);
    chk("R1", "reset overflow", overflow, 1'b0);

    // R2 R3 R4 R5: every format, bit 7 set to exercise the 7-bit mask
    for (int f = 0; f < 16; f++) begin
      cur_req = "R2 R3 R4 R5";
      {data8, stop2, par_en, par_odd} = 4'(f);
      wr(8'h80 | 8'(f * 37 + 5));
      wr(8'h5A ^ 8'(f));
      wait_idle();
    end

    // R2 with a tick every cycle
    cur_req = "R2";
    div = 1;
    data8 = 1'b1; par_en = 1'b1; par_odd = 1'b1; stop2 = 1'b0;
    wr(8'hC3); wr(8'h3C);
    wait_idle();

    // R6: sixteen writes in a row, sent back to back
    cur_req = "R6";
    div = 2;
    for (int i = 0; i < 16; i++) wr(8'(i * 17 + 1));
    wait_idle();

    // R8: fill with cts low, then overflow, then full-plus-pop same cycle
    cur_req = "R8";
    cts = 1'b0;
    for (int i = 0; i < 17; i++) wr(8'(i + 100));
    chk("R8", "overflow after 17th write", overflow, 1'b1);
    cts = 1'b1;
    while (!(baud_tick && q.size() == DEPTH)) cyc();
    wr(8'hEE);
    wait_idle();
    chk("R8", "overflow still set", overflow, 1'b1);

    // R7: drop cts mid-frame
    cur_req = "R7";
    div = 3;
    wr(8'h11); wr(8'h22); wr(8'h33);
    while (!m_active) cyc();
    repeat (4) cyc();
    cts = 1'b0;
    repeat (80) cyc();
    chk("R7", "line idle while cts low", txd, 1'b1);
    chk("R7", "queue still holding", empty_req, 1'b0);
    cts = 1'b1;
    wait_idle();

    // R9: empty_req while the last frame is still on the line
    cur_req = "R9";
    wr(8'h96);
    chk("R9", "empty_req after write", empty_req, 1'b0);
    while (!m_active) cyc();
    cyc();
    chk("R9", "empty_req during last frame", empty_req, 1'b1);
    wait_idle();

    // R10: freeze with writes and ticks arriving
    cur_req = "R10";
    wr(8'hA7); wr(8'h4D);
    while (!m_active) cyc();
    repeat (5) cyc();
    clk_stop = 1'b1;
    for (int i = 0; i < 40; i++) begin
      wr_en = i[0];
      wr_data = 8'(i);
      cyc();
    end
    wr_en = 1'b0;
    clk_stop = 1'b0;
    wait_idle();
    clk_stop = 1'b1;
    wr(8'h77);
    chk("R10", "empty_req held while stopped", empty_req, 1'b1);
    clk_stop = 1'b0;
    cyc();

    // R11: format changes during a frame
    cur_req = "R11";
    data8 = 1'b1; par_en = 1'b1; par_odd = 1'b0; stop2 = 1'b0;
    wr(8'hF1); wr(8'h0E);
    while (!m_active) cyc();
    cyc();
    data8 = 1'b0; par_odd = 1'b1; stop2 = 1'b1;
    wait_idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule